// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer

A 16-bit down-counter behind a small word-addressed register port. It works either as a periodic timer that raises an interrupt each time it runs past zero, or as a watchdog that software must keep servicing. Counting advances on a slow clock-enable input, divided by 1, 16 or 256. It pauses while a debug-halt input is high, and it can also pause during power-down if software asks for that.

Watchdog mode is entered by writing the control register with its watchdog bit set. The counter reloads and starts counting down at once, and the load and control registers become read-only. Only a power-on reset clears that state. A system reset leaves an armed watchdog running. Any write to the service register reloads the count. If the count runs out, the block reloads and either raises the interrupt or emits a one-cycle system reset request, depending on a control bit.

Top module: `dual_watchdog`

## Requirements
- R1: While `por_n` is low, and after it is released, the load and value registers read 0x0050, the control register reads 0x0000, and `irq` and `rst_req` are low.
- R2: The register offsets on `addr` are 0x0 load (read/write), 0x4 value (read-only; writes have no effect), 0x8 control (read/write) and 0xC service (write-only; reads return 0). `rdata` shows the addressed register combinationally.
- R3: Control bit 7 enables normal mode. Each prescaled step decrements the count. A step taken while the count is 0 reloads it from the load register and sets `irq`.
- R4: Control bits 3:2 select the prescale: 00 divides by 1, 01 by 16, and 10 or 11 by 256. The prescaler restarts on every accepted control write.
- R5: In normal mode a write to 0xC clears a pending `irq`. An expiry in the same cycle wins, and `irq` stays set.
- R6: An accepted control write with bit 5 set enters watchdog mode. It reloads the count from the load register and restarts the prescaler. Once in watchdog mode, counting proceeds regardless of bit 7.
- R7: In watchdog mode any write to 0xC, whatever its data, reloads the count, restarts the prescaler and clears `irq`.
- R8: In watchdog mode an expiry reloads the count. If control bit 1 is 1, `rst_req` is high for exactly the one cycle after the expiring edge. If bit 1 is 0, `irq` is set instead.
- R9: In watchdog mode, writes to the load and control registers are ignored until `por_n` goes low.
- R10: A low `sys_rst_n` outside watchdog mode restores the R1 state. In watchdog mode it leaves configuration, count and `irq` untouched, counting continues, and bus writes are ignored.
- R11: While `dbg_halt` is high, neither the count nor the prescaler advances.
- R12: `pwr_down` stops counting only while control bit 0 is 1. With bit 0 at 0, counting continues through power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, synchronous |
| tick_en | input | 1 | Slow clock enable, one pulse per count tick |
| dbg_halt | input | 1 | Debugger holds the counter |
| pwr_down | input | 1 | Power-down indicator |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| irq | output | 1 | Pending timer interrupt |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Every result is due at the clock edge that samples its cause. A write, a reload, a decrement, a change in `irq` and a `rst_req` pulse all show one edge after the inputs are driven, and `rdata` follows `addr` with no added delay. Inputs are driven on the falling edge. The bench's behavioural model advances once per rising edge from the same inputs, and `irq`, `rst_req` and `rdata` are compared with the model one time unit after every rising edge. A late or early reload, or a pulse that is too long, therefore shows up in the first cycle it occurs.

// File: rtl/dwdt_pkg.sv
package dwdt_pkg;

  localparam int unsigned ADDR_W = 4;
  localparam int unsigned PRE_W  = 8;

  typedef enum logic [ADDR_W-1:0] {
    OFS_LOAD  = 4'h0,
    OFS_VALUE = 4'h4,
    OFS_CTRL  = 4'h8,
    OFS_KICK  = 4'hC
  } reg_ofs_e;

  // control bit positions
  localparam int unsigned B_PDSTOP = 0;
  localparam int unsigned B_RSTSEL = 1;
  localparam int unsigned B_PSEL   = 2;
  localparam int unsigned B_WDOG   = 5;
  localparam int unsigned B_RUN    = 7;

  // last prescaler state before a step: divide-1
  function automatic logic [PRE_W-1:0] presc_last(input logic [1:0] sel);
    case (sel)
      2'b00:   presc_last = '0;
      2'b01:   presc_last = PRE_W'(15);
      default: presc_last = PRE_W'(255);
    endcase
  endfunction

endpackage

// File: rtl/dwdt_regs.sv
module dwdt_regs
  import dwdt_pkg::*;
#(
  parameter int unsigned     CNT_W    = 16,
  parameter logic [CNT_W-1:0] LOAD_RST = 16'h0050
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               sys_rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CNT_W-1:0]   wdata,
  input  logic [CNT_W-1:0]   count_i,
  output logic [CNT_W-1:0]   load_q,
  output logic [CNT_W-1:0]   ctrl_q,
  output logic [CNT_W-1:0]   rdata,
  output logic               wd_mode,
  output logic               ctrl_wr,
  output logic               enter_wd,
  output logic               kick,
  output logic               soft_clr
);

  logic bus_ok;
  logic load_wr;

  assign wd_mode  = ctrl_q[B_WDOG];
  assign bus_ok   = sys_rst_n;
  assign soft_clr = !sys_rst_n && !wd_mode;
  assign ctrl_wr  = bus_ok && wr_en && (addr == OFS_CTRL) && !wd_mode;
  assign load_wr  = bus_ok && wr_en && (addr == OFS_LOAD) && !wd_mode;
  assign enter_wd = ctrl_wr && wdata[B_WDOG];
  assign kick     = bus_ok && wr_en && (addr == OFS_KICK);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      load_q <= LOAD_RST;
      ctrl_q <= '0;
    end else if (soft_clr) begin
      load_q <= LOAD_RST;
      ctrl_q <= '0;
    end else begin
      if (load_wr) load_q <= wdata;
      if (ctrl_wr) ctrl_q <= wdata;
    end
  end

  always_comb begin
    case (addr)
      OFS_LOAD:  rdata = load_q;
      OFS_VALUE: rdata = count_i;
      OFS_CTRL:  rdata = ctrl_q;
      default:   rdata = '0;
    endcase
  end

  // R9
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!por_n)
    wd_mode |=> ($stable(load_q) && $stable(ctrl_q)));

  // R6
  wd_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    wd_mode |=> wd_mode);

endmodule

// File: rtl/dwdt_prescaler.sv
module dwdt_prescaler
  import dwdt_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       clr,
  input  logic       tick_q,
  input  logic [1:0] psel,
  output logic       step
);

  logic [PRE_W-1:0] pre_q;
  logic             wrap;

  assign wrap = (pre_q >= presc_last(psel));
  assign step = tick_q && wrap;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        pre_q <= '0;
    else if (clr)      pre_q <= '0;
    else if (tick_q)   pre_q <= wrap ? '0 : pre_q + 1'b1;
  end

  // R11
  pre_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!tick_q && !clr) |=> $stable(pre_q));

  // R4
  pre_restart_chk: assert property (@(posedge clk) disable iff (!por_n)
    clr |=> (pre_q == '0));

endmodule

// File: rtl/dwdt_counter.sv
module dwdt_counter #(
  parameter int unsigned      CNT_W    = 16,
  parameter logic [CNT_W-1:0] LOAD_RST = 16'h0050
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             soft_clr,
  input  logic [CNT_W-1:0] load_i,
  input  logic             reload,
  input  logic             step,
  input  logic             wd_mode,
  input  logic             rst_sel,
  input  logic             kick,
  output logic [CNT_W-1:0] count_q,
  output logic             irq,
  output logic             rst_req,
  output logic             expire
);

  logic to_reset;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] ld);
    next_count = (cur == '0) ? ld : cur - 1'b1;
  endfunction

  assign expire   = step && !reload && (count_q == '0);
  assign to_reset = wd_mode && rst_sel;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      count_q <= LOAD_RST;
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else if (soft_clr) begin
      count_q <= LOAD_RST;
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (reload)    count_q <= load_i;
      else if (step) count_q <= next_count(count_q, load_i);
      if (expire && !to_reset) irq <= 1'b1;
      else if (kick)           irq <= 1'b0;
      rst_req <= expire && to_reset;
    end
  end

  // R8
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |=> !rst_req);

  // R8
  rst_only_wd_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |-> wd_mode);

  // R3
  expire_at_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    expire |-> (count_q == '0));

  // R7
  reload_value_chk: assert property (@(posedge clk) disable iff (!por_n)
    (reload && !soft_clr) |=> (count_q == $past(load_i)));

endmodule

// File: rtl/dual_watchdog.sv
module dual_watchdog
  import dwdt_pkg::*;
#(
  parameter int unsigned      CNT_W    = 16,
  parameter logic [CNT_W-1:0] LOAD_RST = 16'h0050
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              tick_en,
  input  logic              dbg_halt,
  input  logic              pwr_down,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq,
  output logic              rst_req
);

  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] ctrl_q;
  logic [CNT_W-1:0] count_q;
  logic wd_mode, ctrl_wr, enter_wd, kick, soft_clr;
  logic wd_kick, reload, running, hold, tick_q, pre_clr, step, expire;

  assign wd_kick = kick && wd_mode;
  assign reload  = enter_wd || wd_kick;
  assign running = wd_mode || ctrl_q[B_RUN];
  assign hold    = dbg_halt || (pwr_down && ctrl_q[B_PDSTOP]);
  assign tick_q  = tick_en && running && !hold && !ctrl_wr && !wd_kick && !soft_clr;
  assign pre_clr = soft_clr || ctrl_wr || wd_kick;

  dwdt_regs #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST)) u_regs (
    .clk      (clk),
    .por_n    (por_n),
    .sys_rst_n(sys_rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .count_i  (count_q),
    .load_q   (load_q),
    .ctrl_q   (ctrl_q),
    .rdata    (rdata),
    .wd_mode  (wd_mode),
    .ctrl_wr  (ctrl_wr),
    .enter_wd (enter_wd),
    .kick     (kick),
    .soft_clr (soft_clr)
  );

  dwdt_prescaler u_presc (
    .clk   (clk),
    .por_n (por_n),
    .clr   (pre_clr),
    .tick_q(tick_q),
    .psel  (ctrl_q[B_PSEL+1:B_PSEL]),
    .step  (step)
  );

  dwdt_counter #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST)) u_cnt (
    .clk     (clk),
    .por_n   (por_n),
    .soft_clr(soft_clr),
    .load_i  (load_q),
    .reload  (reload),
    .step    (step),
    .wd_mode (wd_mode),
    .rst_sel (ctrl_q[B_RSTSEL]),
    .kick    (kick),
    .count_q (count_q),
    .irq     (irq),
    .rst_req (rst_req),
    .expire  (expire)
  );

  // R11
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!por_n)
    (dbg_halt && !reload && !soft_clr) |=> $stable(count_q));

  // R12
  pd_freeze_chk: assert property (@(posedge clk) disable iff (!por_n)
    (pwr_down && ctrl_q[B_PDSTOP] && !reload && !soft_clr) |=> $stable(count_q));

  // R10
  sysrst_keeps_wd_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst_n && wd_mode) |=> (wd_mode && $stable(load_q)));

endmodule

// File: tb/dual_watchdog_bench.sv
`timescale 1ns/1ps
module dual_watchdog_bench;

  logic        clk = 1'b0;
  logic        por_n, sys_rst_n, tick_en, dbg_halt, pwr_down, wr_en;
  logic [3:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        irq, rst_req;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // reference state
  logic [15:0] m_load, m_cnt, m_ctrl;
  logic        m_irq, m_rst;
  int          m_pre;

  always #2 clk = ~clk;

  dual_watchdog u_dual_watchdog (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .tick_en(tick_en),
    .dbg_halt(dbg_halt), .pwr_down(pwr_down), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
  );

  task automatic model_defaults();
    m_load = 16'h0050; m_cnt = 16'h0050; m_ctrl = 16'h0000;
    m_irq = 1'b0; m_rst = 1'b0; m_pre = 0;
  endtask

  task automatic model_edge();
    bit wdm, cw, lw, kk, qual, stp, ev;
    int dv;
    wdm = m_ctrl[5];
    if (!por_n || (!sys_rst_n && !wdm)) begin
      model_defaults();
      return;
    end
    cw = sys_rst_n && wr_en && addr == 4'h8 && !wdm;
    lw = sys_rst_n && wr_en && addr == 4'h0 && !wdm;
    kk = sys_rst_n && wr_en && addr == 4'hC;
    case (m_ctrl[3:2])
      2'd0: dv = 1;
      2'd1: dv = 16;
      default: dv = 256;
    endcase
    qual = tick_en && (wdm || m_ctrl[7]) && !(dbg_halt || (pwr_down && m_ctrl[0]));
    stp = 0; ev = 0;
    if (cw || (wdm && kk)) m_pre = 0;
    else if (qual) begin
      if (m_pre + 1 >= dv) begin m_pre = 0; stp = 1; end
      else m_pre = m_pre + 1;
    end
    if ((cw && wdata[5]) || (wdm && kk)) m_cnt = m_load;
    else if (stp) begin
      if (m_cnt == 0) begin ev = 1; m_cnt = m_load; end
      else m_cnt = m_cnt - 1;
    end
    m_rst = ev && wdm && m_ctrl[1];
    if (ev && !(wdm && m_ctrl[1])) m_irq = 1'b1;
    else if (kk) m_irq = 1'b0;
    if (cw) m_ctrl = wdata;
    if (lw) m_load = wdata;
  endtask

  function automatic logic [15:0] model_read(input logic [3:0] a);
    case (a)
      4'h0: return m_load;
      4'h4: return m_cnt;
      4'h8: return m_ctrl;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  // one clock: inputs already set before the falling edge completes
  task automatic cyc();
    @(posedge clk);
    model_edge();
    #1;
    check("irq", {15'd0, irq}, {15'd0, m_irq});
    check("rst_req", {15'd0, rst_req}, {15'd0, m_rst});
    check("rdata", rdata, model_read(addr));
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    cyc();
    addr = 4'h4;
  endtask

  task automatic run(input int n, input bit tk);
    for (int i = 0; i < n; i++) begin tick_en = tk; cyc(); end
  endtask

  task automatic rd(input logic [3:0] a);
    addr = a; cyc(); addr = 4'h4;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    model_defaults();
    por_n = 1'b0; sys_rst_n = 1'b1; tick_en = 1'b0; dbg_halt = 1'b0;
    pwr_down = 1'b0; wr_en = 1'b0; addr = 4'h0; wdata = '0;
    @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    run(3, 1);
    por_n = 1'b1;
    rd(4'h0); rd(4'h4); rd(4'h8);
    // R2 value register is read-only, service reads zero
    cur_req = "R2";
    wr(4'h4, 16'h1234); rd(4'h4); rd(4'hC); rd(4'h0);
    // R3 normal mode, divide by 1
    cur_req = "R3";
    wr(4'h0, 16'd5); wr(4'h8, 16'h0080);
    run(20, 1);
    // R5 service clears interrupt
    cur_req = "R5";
    wr(4'hC, 16'h00A5); run(3, 0);
    // R4 divide by 16 and 256
    cur_req = "R4";
    wr(4'h0, 16'd3); wr(4'h8, 16'h0084); run(80, 1);
    wr(4'h8, 16'h008C); wr(4'h0, 16'd1); run(600, 1);
    wr(4'h8, 16'h0088); run(530, 1);
    wr(4'h8, 16'h0080); wr(4'h0, 16'd4);
    // R11 debug halt
    cur_req = "R11";
    dbg_halt = 1'b1; run(10, 1); dbg_halt = 1'b0; run(8, 1);
    // R12 power-down with and without stop bit
    cur_req = "R12";
    pwr_down = 1'b1; run(8, 1);
    wr(4'h8, 16'h0081); run(10, 1);
    pwr_down = 1'b0; run(6, 1);
    // R10 system reset outside watchdog mode
    cur_req = "R10";
    sys_rst_n = 1'b0; run(2, 1); sys_rst_n = 1'b1;
    rd(4'h8); rd(4'h0);
    // R6 enter watchdog, interrupt select, bit7 clear
    cur_req = "R6";
    wr(4'h0, 16'd10); run(3, 1); wr(4'h8, 16'h0020); rd(4'h4);
    run(15, 1);
    // R7 service reloads
    cur_req = "R7";
    for (int k = 0; k < 5; k++) begin run(6, 1); wr(4'hC, 16'(k * 77)); end
    run(4, 1);
    // R9 lock
    cur_req = "R9";
    wr(4'h0, 16'h7777); rd(4'h0); wr(4'h8, 16'h0000); rd(4'h8);
    // R10 system reset in watchdog mode keeps running
    cur_req = "R10";
    sys_rst_n = 1'b0; wr(4'hC, 16'h0); run(14, 1); sys_rst_n = 1'b1;
    rd(4'h8); rd(4'h0);
    // R1 power-on reset leaves watchdog mode
    cur_req = "R1";
    por_n = 1'b0; run(2, 1); por_n = 1'b1; rd(4'h8); rd(4'h4);
    // R8 reset-request select
    cur_req = "R8";
    wr(4'h0, 16'd4); wr(4'h8, 16'h0022); run(20, 1);
    wr(4'hC, 16'h0001); run(12, 1);
    // mixed random stimulus, normal then watchdog
    cur_req = "R3";
    por_n = 1'b0; run(1, 0); por_n = 1'b1;
    wr(4'h0, 16'd7); wr(4'h8, 16'h0080);
    for (int i = 0; i < 600; i++) begin
      if (i == 300) begin cur_req = "R8"; wr(4'h8, 16'h0022); end
      tick_en  = ($urandom_range(0, 3) != 0);
      dbg_halt = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 19) == 0) begin
        addr = 4'hC; wdata = 16'($urandom); wr_en = 1'b1;
      end else addr = 4'(4 * $urandom_range(0, 3));
      cyc();
    end
    dbg_halt = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule